// File: doc/BRIEF.md
# Reset and Exception Vector Sequencer

This block starts a small CPU core and redirects it when an exception is taken. It filters the active-low reset pin so that only a sufficiently long low pulse counts. A one-cycle watchdog strobe can also start a reset. On any reset the core's control registers are forced to their reset values: the vector base, the condition-code mask bit, the extended status bits and the interrupt control mode.

After register initialisation, the sequencer performs exactly one memory read through a request/acknowledge port. The word returned is loaded into the program counter, and the core is then released to run.

Exception requests come with a type code. The block forms the vector table address from a built-in offset table. Reset and address-error vectors are absolute addresses. Every other vector is relative to the vector base register.

The core's register write path passes through this block. Reset can therefore override writes, and writes are blocked while a vector fetch is in flight.

Top module: `exc_vector_sequencer`

## Requirements
- R1: A reset is accepted only when `rstPinN` has been sampled low on at least MIN_LOW (default 20) consecutive clock edges. A shorter low pulse changes no register and starts no sequence.
- R2: On an accepted reset, the outputs hold these values from the first cycle after acceptance until the vector fetch completes: `vbrOut` = 0x00000000, `ccrOut` = 0x80 (bit 7 is the interrupt mask), `exrOut` = 0x07 (bit 7 is the trace bit and is 0; bits 2:0 are the mask bits and are 1), `intModeOut` = 0 and `pcOut` = 0.
- R3: On the first clock edge that samples `rstPinN` high after an accepted reset, the sequencer starts a fetch. The fetch address is 0x00000000, whatever value the vector base held before.
- R4: `memReq` stays high with `memAddr` unchanged until `memAck`. `memData` is captured into `pcOut` on the edge where `memAck` is high.
- R5: `done` is high for exactly the one cycle after the acknowledging edge. `busy` is high from the start of a fetch until that same edge, and `done` and `busy` are never high together.
- R6: A one-cycle `wdtStrobe` outside pin reset runs the same sequence as the pin: the registers take the R2 values and a fetch starts at address 0 on the next cycle.
- R7: An exception with `excCode` = 0 (address error) fetches from the absolute address 0x00000010, ignoring the vector base.
- R8: An exception with `excCode` = n, where n is 1 or more, fetches from `vbrOut` + 0x20 + 4*(n-1).
- R9: Reset has priority over everything else. An accepted reset abandons a fetch in flight: `memReq` drops, `busy` drops and `pcOut` is not loaded. While the reset is accepted, exceptions, watchdog strobes and writes are ignored.
- R10: A write with `regWrEn` is taken only when no fetch is in flight and no reset is accepted. `regWrSel` selects the target: 0 writes `vbrOut` (32 bits), 1 writes `ccrOut` (bits 7:0), 2 writes `exrOut` (bits 7:0) and 3 writes `intModeOut` (bits 1:0).
- R11: `excReq` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstPinN | input | 1 | Reset pin, active low, already synchronous to `clk` |
| wdtStrobe | input | 1 | Watchdog overflow reset request, one cycle |
| excReq | input | 1 | Exception request, one cycle |
| excCode | input | CODE_W | Exception type code |
| regWrEn | input | 1 | Core register write enable |
| regWrSel | input | 2 | Core register select |
| regWrData | input | 32 | Core register write data |
| memReq | output | 1 | Vector read request |
| memAddr | output | 32 | Vector read address |
| memAck | input | 1 | Vector read acknowledge |
| memData | input | 32 | Vector read data |
| pcOut | output | 32 | Program counter |
| vbrOut | output | 32 | Vector base register |
| ccrOut | output | 8 | Condition code register |
| exrOut | output | 8 | Extended status register |
| intModeOut | output | 2 | Interrupt control mode |
| busy | output | 1 | Vector fetch in flight |
| done | output | 1 | Sequence finished, one-cycle pulse |

## Verification
The hardest state to reach from the ports is a qualified pin reset arriving while a vector fetch is still unacknowledged. The stimulus reaches it by raising an exception with a non-zero vector base and then withholding `memAck`. While the fetch waits, the reset pin is held low past the minimum count. The bench then confirms that the request dropped, that the program counter holds its reset value rather than fetched data, and that the release fetches from address zero. The pulse-length boundary is covered by one pulse a single cycle short of the minimum and one pulse exactly at it.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  localparam int REG8_W = 8;

  localparam logic [7:0] CCR_RESET = 8'h80;
  localparam logic [7:0] EXR_RESET = 8'h07;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_FETCH = 2'd2
  } seqState_t;

  typedef struct packed {
    logic initRegs;
    logic selRstVec;
    logic selExcVec;
    logic loadPc;
    logic wrEn;
  } seqStrobe_t;

endpackage

// File: rtl/exc_vec_ctrl.sv
module exc_vec_ctrl
  import exc_vec_pkg::*;
#(
  parameter int MIN_LOW = 20
) (
  input  logic       clk,
  input  logic       rstPinN,
  input  logic       wdtStrobe,
  input  logic       excReq,
  input  logic       memAck,
  input  logic       regWrEn,
  output seqStrobe_t stb,
  output logic       qualified,
  output logic       running,
  output logic       busy,
  output logic       memReq,
  output logic       done
);

  logic [MIN_LOW-1:0] lowHist;
  seqState_t state, nxtState;

  // shift history of low samples; all ones means the pulse is long enough
  always_ff @(posedge clk) begin
    lowHist <= {lowHist[MIN_LOW-2:0], ~rstPinN};
  end

  assign qualified = &lowHist;

  always_comb begin
    stb      = '0;
    nxtState = state;
    if (qualified) begin
      stb.initRegs = 1'b1;
      if (rstPinN) begin
        stb.selRstVec = 1'b1;
        nxtState      = ST_FETCH;
      end else begin
        nxtState = ST_HOLD;
      end
    end else if (state == ST_HOLD) begin
      nxtState = ST_HOLD;
    end else if (wdtStrobe) begin
      stb.initRegs  = 1'b1;
      stb.selRstVec = 1'b1;
      nxtState      = ST_FETCH;
    end else begin
      case (state)
        ST_RUN: begin
          stb.wrEn = regWrEn;
          if (excReq) begin
            stb.selExcVec = 1'b1;
            nxtState      = ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (memAck) begin
            stb.loadPc = 1'b1;
            nxtState   = ST_RUN;
          end
        end
        default: nxtState = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    state <= nxtState;
    done  <= stb.loadPc;
  end

  assign busy    = (state == ST_FETCH);
  assign memReq  = (state == ST_FETCH);
  assign running = (state == ST_RUN);

  // R5: the completion pulse and the busy flag never overlap
  assert_done_busy_R5: assert property (@(posedge clk) disable iff (!rstPinN)
    done |-> !busy);

  // R6: a watchdog strobe outside pin reset makes the block busy next cycle
  assert_wdt_start_R6: assert property (@(posedge clk) disable iff (!rstPinN)
    (wdtStrobe && !qualified && state != ST_HOLD) |=> busy);

  // R11: an exception request while busy does not restart anything
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rstPinN)
    (busy && excReq && !memAck && !wdtStrobe && !qualified) |=> busy && !done);

endmodule

// File: rtl/exc_vec_dpath.sv
module exc_vec_dpath
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rstPinN,
  input  seqStrobe_t        stb,
  input  logic [CODE_W-1:0] excCode,
  input  logic [1:0]        regWrSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] vbr,
  output logic [REG8_W-1:0] ccr,
  output logic [REG8_W-1:0] exr,
  output logic [1:0]        intMode
);

  localparam logic [ADDR_W-1:0] RST_OFFSET  = '0;
  localparam logic [ADDR_W-1:0] ERR_OFFSET  = ADDR_W'(32'h10);
  localparam logic [ADDR_W-1:0] BASE_OFFSET = ADDR_W'(32'h20);
  localparam logic [ADDR_W-1:0] STEP        = ADDR_W'(4);

  logic [ADDR_W-1:0] codeWide;
  logic [ADDR_W-1:0] excVecAddr;

  assign codeWide = ADDR_W'(excCode);

  always_comb begin
    if (excCode == '0) begin
      excVecAddr = ERR_OFFSET;
    end else begin
      excVecAddr = vbr + BASE_OFFSET + (codeWide - ADDR_W'(1)) * STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.initRegs) begin
      vbr     <= '0;
      ccr     <= CCR_RESET;
      exr     <= EXR_RESET;
      intMode <= 2'd0;
      pc      <= '0;
    end else begin
      if (stb.wrEn) begin
        case (regWrSel)
          2'd0: vbr     <= regWrData;
          2'd1: ccr     <= regWrData[REG8_W-1:0];
          2'd2: exr     <= regWrData[REG8_W-1:0];
          default: intMode <= regWrData[1:0];
        endcase
      end
      if (stb.loadPc) begin
        pc <= memData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.selRstVec) begin
      memAddr <= RST_OFFSET;
    end else if (stb.selExcVec) begin
      memAddr <= excVecAddr;
    end
  end

  // R4: the program counter only moves on a load or a reset
  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rstPinN)
    (!stb.loadPc && !stb.initRegs) |=> $stable(pc));

endmodule

// File: rtl/exc_vector_sequencer.sv
module exc_vector_sequencer
  import exc_vec_pkg::*;
#(
  parameter int MIN_LOW = 20,
  parameter int ADDR_W  = 32,
  parameter int CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rstPinN,
  input  logic              wdtStrobe,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic              regWrEn,
  input  logic [1:0]        regWrSel,
  input  logic [ADDR_W-1:0] regWrData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [ADDR_W-1:0] memData,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] vbrOut,
  output logic [REG8_W-1:0] ccrOut,
  output logic [REG8_W-1:0] exrOut,
  output logic [1:0]        intModeOut,
  output logic              busy,
  output logic              done
);

  seqStrobe_t stb;
  logic       qualified;
  logic       running;

  exc_vec_ctrl #(.MIN_LOW(MIN_LOW)) i_ctrl (
    .clk       (clk),
    .rstPinN   (rstPinN),
    .wdtStrobe (wdtStrobe),
    .excReq    (excReq),
    .memAck    (memAck),
    .regWrEn   (regWrEn),
    .stb       (stb),
    .qualified (qualified),
    .running   (running),
    .busy      (busy),
    .memReq    (memReq),
    .done      (done)
  );

  exc_vec_dpath #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) i_dpath (
    .clk       (clk),
    .rstPinN   (rstPinN),
    .stb       (stb),
    .excCode   (excCode),
    .regWrSel  (regWrSel),
    .regWrData (regWrData),
    .memData   (memData),
    .memAddr   (memAddr),
    .pc        (pcOut),
    .vbr       (vbrOut),
    .ccr       (ccrOut),
    .exr       (exrOut),
    .intMode   (intModeOut)
  );

  // R4: an unacknowledged request keeps its address
  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rstPinN)
    (memReq && !memAck && !qualified && !wdtStrobe) |=> memReq && $stable(memAddr));

  // R3: the release edge starts a fetch at address zero
  assert_rst_vec_R3: assert property (@(posedge clk) disable iff (!rstPinN)
    (qualified && rstPinN) |=> memReq && memAddr == '0);

  // R2: register reset values are in place once the fetch starts
  assert_rst_init_R2: assert property (@(posedge clk) disable iff (!rstPinN)
    (qualified && rstPinN) |=> vbrOut == '0 && ccrOut == 8'h80 && exrOut == 8'h07
                               && intModeOut == 2'd0);

  // R7: the address-error vector is absolute
  assert_addr_err_R7: assert property (@(posedge clk) disable iff (!rstPinN)
    (running && excReq && excCode == '0 && !qualified && !wdtStrobe)
      |=> memAddr == ADDR_W'(32'h10));

endmodule

// File: tb/test_exc_vector_sequencer.sv
module test_exc_vector_sequencer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstPinN = 1'b0;
  logic        wdtStrobe = 1'b0;
  logic        excReq = 1'b0;
  logic [2:0]  excCode = '0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrSel = '0;
  logic [31:0] regWrData = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memAck = 1'b0;
  logic [31:0] memData = '0;
  logic [31:0] pcOut;
  logic [31:0] vbrOut;
  logic [7:0]  ccrOut;
  logic [7:0]  exrOut;
  logic [1:0]  intModeOut;
  logic        busy;
  logic        done;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vector_sequencer i_exc_vector_sequencer (
    .clk(clk), .rstPinN(rstPinN), .wdtStrobe(wdtStrobe), .excReq(excReq),
    .excCode(excCode), .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .memReq(memReq), .memAddr(memAddr), .memAck(memAck), .memData(memData),
    .pcOut(pcOut), .vbrOut(vbrOut), .ccrOut(ccrOut), .exrOut(exrOut),
    .intModeOut(intModeOut), .busy(busy), .done(done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pinPulse(input int lowCycles);
    @(negedge clk);
    rstPinN = 1'b0;
    repeat (lowCycles) @(posedge clk);
    @(negedge clk);
    rstPinN = 1'b1;
    @(negedge clk);
  endtask

  task automatic raiseExc(input logic [2:0] code);
    @(negedge clk);
    excReq = 1'b1; excCode = code;
    @(negedge clk);
    excReq = 1'b0;
  endtask

  task automatic serveRead(input string tag, input logic [31:0] expAddr,
                           input logic [31:0] data);
    for (int i = 0; i < 40 && !memReq; i++) @(negedge clk);
    check({tag, " R4 memReq"}, 32'(memReq), 32'd1);
    check({tag, " address"}, memAddr, expAddr);
    repeat (2) @(negedge clk);
    check({tag, " R4 address stable"}, memAddr, expAddr);
    check({tag, " R5 busy"}, 32'(busy), 32'd1);
    memAck = 1'b1; memData = data;
    @(negedge clk);
    memAck = 1'b0; memData = '0;
    check({tag, " R4 pc load"}, pcOut, data);
    check({tag, " R5 done"}, 32'(done), 32'd1);
    check({tag, " R5 busy low"}, 32'(busy), 32'd0);
    @(negedge clk);
    check({tag, " R5 done width"}, 32'(done), 32'd0);
  endtask

  task automatic testPowerReset();
    repeat (25) @(posedge clk);
    @(negedge clk);
    rstPinN = 1'b1;
    @(negedge clk);
    check("R2 vbr", vbrOut, 32'h0);
    check("R2 ccr", 32'(ccrOut), 32'h80);
    check("R2 exr", 32'(exrOut), 32'h07);
    check("R2 mode", 32'(intModeOut), 32'h0);
    check("R2 pc", pcOut, 32'h0);
    serveRead("R3 power-on fetch", 32'h0, 32'h0000_1000);
  endtask

  task automatic testShortPulse();
    writeReg(2'd0, 32'h0000_4000);
    writeReg(2'd1, 32'h0000_0011);
    writeReg(2'd2, 32'h0000_0080);
    writeReg(2'd3, 32'h0000_0002);
    check("R10 vbr write", vbrOut, 32'h4000);
    check("R10 ccr write", 32'(ccrOut), 32'h11);
    check("R10 exr write", 32'(exrOut), 32'h80);
    check("R10 mode write", 32'(intModeOut), 32'h2);
    pinPulse(19);
    repeat (2) @(negedge clk);
    check("R1 short pulse busy", 32'(busy), 32'd0);
    check("R1 short pulse memReq", 32'(memReq), 32'd0);
    check("R1 short pulse vbr", vbrOut, 32'h4000);
    check("R1 short pulse exr", 32'(exrOut), 32'h80);
    check("R1 short pulse mode", 32'(intModeOut), 32'h2);
    check("R1 short pulse pc", pcOut, 32'h1000);
  endtask

  task automatic testMinPulse();
    pinPulse(20);
    check("R1 min pulse busy", 32'(busy), 32'd1);
    check("R2 min pulse vbr", vbrOut, 32'h0);
    check("R2 min pulse exr", 32'(exrOut), 32'h07);
    check("R2 min pulse ccr", 32'(ccrOut), 32'h80);
    check("R2 min pulse mode", 32'(intModeOut), 32'h0);
    serveRead("R3 min pulse fetch", 32'h0, 32'h0000_2000);
  endtask

  task automatic testExceptions();
    writeReg(2'd0, 32'h0000_4000);
    raiseExc(3'd0);
    serveRead("R7 address error", 32'h10, 32'h0000_3000);
    raiseExc(3'd3);
    serveRead("R8 code 3", 32'h4028, 32'h0000_3100);
    raiseExc(3'd1);
    check("R10 write blocked setup busy", 32'(busy), 32'd1);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = 2'd0; regWrData = 32'h0000_9999;
    excReq = 1'b1; excCode = 3'd5;
    @(negedge clk);
    regWrEn = 1'b0; excReq = 1'b0;
    serveRead("R8 code 1", 32'h4020, 32'h0000_3200);
    check("R10 write ignored while busy", vbrOut, 32'h4000);
    repeat (2) @(negedge clk);
    check("R11 request ignored while busy", 32'(busy), 32'd0);
    check("R11 pc kept", pcOut, 32'h3200);
  endtask

  task automatic testWatchdog();
    writeReg(2'd2, 32'h0000_0080);
    writeReg(2'd3, 32'h0000_0001);
    @(negedge clk);
    wdtStrobe = 1'b1;
    @(negedge clk);
    wdtStrobe = 1'b0;
    check("R6 wdt busy", 32'(busy), 32'd1);
    check("R6 wdt vbr", vbrOut, 32'h0);
    check("R6 wdt exr", 32'(exrOut), 32'h07);
    check("R6 wdt mode", 32'(intModeOut), 32'h0);
    serveRead("R6 wdt fetch", 32'h0, 32'h0000_5000);
  endtask

  task automatic testAbort();
    writeReg(2'd0, 32'h0000_8000);
    raiseExc(3'd2);
    check("R9 fetch pending", 32'(memReq), 32'd1);
    check("R8 code 2 address", memAddr, 32'h8024);
    rstPinN = 1'b0;
    repeat (21) @(posedge clk);
    @(negedge clk);
    check("R9 abandoned memReq", 32'(memReq), 32'd0);
    check("R9 abandoned busy", 32'(busy), 32'd0);
    check("R9 pc not loaded", pcOut, 32'h0);
    check("R9 done not raised", 32'(done), 32'd0);
    wdtStrobe = 1'b1; excReq = 1'b1; excCode = 3'd4;
    regWrEn = 1'b1; regWrSel = 2'd0; regWrData = 32'h0000_7777;
    @(negedge clk);
    wdtStrobe = 1'b0; excReq = 1'b0; regWrEn = 1'b0;
    check("R9 held in reset", 32'(memReq), 32'd0);
    check("R9 write ignored in reset", vbrOut, 32'h0);
    rstPinN = 1'b1;
    @(negedge clk);
    serveRead("R9 refetch", 32'h0, 32'h0000_6000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired (R1..R11 run incomplete) actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testPowerReset();
    testShortPulse();
    testMinPulse();
    testExceptions();
    testWatchdog();
    testAbort();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule